// File: doc/BRIEF.md
# Interrupt Priority Control Register

This block holds the central interrupt control byte of a small controller and decides, every cycle, whether an incoming interrupt may be taken. Three request sources compete. A non-maskable request always wins. A top-level request is latched into a pending bit and is taken when that bit is enabled. An ordinary request carries a 3-bit priority and competes against the current priority level held in the register. The block shows the winning source on `accept_kind_o`. The interrupt controller commits that choice by pulsing `ack_i`, and it pulses `ret_i` when a service routine returns.

Two arbitration modes are available. In concurrent mode, taking an ordinary request masks all further maskable interrupts until the return. In nested mode, interrupts stay enabled. The preempted priority level is pushed onto an internal save stack that holds seven levels, and it is popped back on return. When that stack is full, further nested acceptance is refused and a sticky overflow flag is raised. Software can read the whole byte and overwrite it in one cycle. Bit 7 of the byte also gates an external timer count enable.

Top module: `intr_prio_ctrl`

## Requirements
- R1: After reset the control byte reads 8'h87, the save stack is empty, the overflow flag is 0 and no source is shown as accepted. The byte is laid out as {bit7 counter enable, bit6 top pending, bit5 top enable, bit4 global enable, bit3 mode (0 concurrent, 1 nested), bits2:0 current level}.
- R2: An ordinary request is accepted (`accept_kind_o` = 1) only when the global enable is 1 and its priority is numerically lower than the current level, where 0 is the most urgent. An equal or larger value is not accepted.
- R3: A non-maskable request is accepted (`accept_kind_o` = 3) whatever the register holds. Acknowledging it leaves the control byte and the stack unchanged.
- R4: In concurrent mode, acknowledging an ordinary request clears the global enable and loads the request's priority into the current level. A return strobe sets the global enable and leaves the level unchanged.
- R5: In nested mode, acknowledging an ordinary request pushes the old level onto the save stack, loads the request's priority and keeps the global enable. A return strobe pops the most recently saved level back into the current level.
- R6: The save stack holds at most 7 levels. While it is full in nested mode, an ordinary request that would otherwise be accepted is refused and sets the sticky overflow flag. Only a software write clears that flag.
- R7: A top-level request sets the pending bit one cycle later, and software may also set that bit by a write. A top-level interrupt is accepted (`accept_kind_o` = 2) when the pending bit, the top enable and the global enable are all 1. Acknowledging it clears the pending bit. When several sources are accepted at once, the order is non-maskable, then top-level, then ordinary.
- R8: `counter_en_o` is the AND of control bit 7 and `timer_ce_i`, with no delay.
- R9: A software write replaces all eight bits in the next cycle and overrides any acknowledge or return in the same cycle, but it does not touch the save stack. A top-level request in the same cycle still sets the pending bit.
- R10: An acknowledge while `accept_kind_o` = 0 changes nothing. A return in nested mode with an empty stack leaves the current level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid_i | input | 1 | Ordinary request present |
| req_prio_i | input | 3 | Priority of the ordinary request, 0 most urgent |
| top_req_i | input | 1 | Top-level request event |
| nmi_req_i | input | 1 | Non-maskable request |
| ack_i | input | 1 | Commit the currently accepted source |
| ret_i | input | 1 | Return from the service routine |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 8 | Software write data |
| timer_ce_i | input | 1 | External timer count enable |
| rd_data_o | output | 8 | Current control byte |
| accept_kind_o | output | 2 | 0 none, 1 ordinary, 2 top-level, 3 non-maskable |
| ovf_o | output | 1 | Sticky save-stack overflow flag |
| save_depth_o | output | 3 | Number of saved levels |
| counter_en_o | output | 1 | Gated timer count enable |

## Verification
A corrupted current level or global enable shows up on `accept_kind_o` in the same cycle as the next ordinary request that probes it. A corrupted level also shows up on `rd_data_o` one cycle after the faulty update. A wrong save stack stays hidden until returns begin to pop it, and then it appears as a wrong level on `rd_data_o` and as a wrong `save_depth_o`. The bench therefore fills the stack to its limit and drains it in full, in addition to running long random stretches. It compares every output against a queue-based model on every clock.

// File: rtl/intr_prio_pkg.sv
// Package: shared types for the interrupt priority control block.
// Assumes an 8-bit control byte whose field order other logic decodes.
package intr_prio_pkg;

    localparam int PRIO_W = 3;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MASK = 2'd1,
        SRC_TOP  = 2'd2,
        SRC_NMI  = 2'd3
    } src_e;

    typedef struct packed {
        logic              gce;   // counter enable
        logic              tlip;  // top-level pending
        logic              tli;   // top-level enable
        logic              gie;   // global interrupt enable
        logic              nest;  // 1 = nested, 0 = concurrent
        logic [PRIO_W-1:0] cpl;   // current level, 0 most urgent
    } ctl_reg_t;

    localparam ctl_reg_t CTL_RESET = 8'h87;

endpackage

// File: rtl/prio_save_lifo.sv
// Module: prio_save_lifo
// Last-in first-out store for preempted priority levels.
// Assumes push and pop are never requested together. A push while full
// and a pop while empty are ignored. Entries carry no reset; only the
// occupancy count does.
module prio_save_lifo #(
    parameter int DEPTH = 7,
    parameter int W     = 3,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic          full,
    output logic          empty,
    output logic [CW-1:0] count
);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] top_idx;

    // Occupancy flags and the index of the newest entry.
    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        top_idx = AW'(count - 1'b1);
        dout    = empty ? '0 : mem[top_idx];
    end

    // Track the number of stored levels.
    always_ff @(posedge clk) begin
        if (!rst_n)                count <= '0;
        else if (push && !full)    count <= count + 1'b1;
        else if (pop && !empty)    count <= count - 1'b1;
    end

    // One storage slot per level; a slot is written when it is the next free one.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (push && !full && (count == CW'(i)))
                mem[i] <= din;
        end
    end

    p_push_grow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full) |=> (count == $past(count) + 1'b1));

    p_full_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);

endmodule

// File: rtl/prio_arbiter.sv
// Module: prio_arbiter
// Combinational choice among the three request sources against the
// current control state. Also reports when an ordinary request that
// outranks the current level is refused because the save stack is full.
module prio_arbiter
    import intr_prio_pkg::*;
(
    input  logic              req_valid,
    input  logic [PRIO_W-1:0] req_prio,
    input  logic              nmi_req,
    input  logic              tlip,
    input  logic              tli,
    input  logic              gie,
    input  logic              nest,
    input  logic [PRIO_W-1:0] cpl,
    input  logic              stack_full,
    output src_e              kind,
    output logic              blocked
);

    logic outranks;

    // Fixed source order: non-maskable, top-level, ordinary.
    always_comb begin
        outranks = req_valid && gie && (req_prio < cpl);
        blocked  = outranks && nest && stack_full;
        if (nmi_req)                    kind = SRC_NMI;
        else if (tlip && tli && gie)    kind = SRC_TOP;
        else if (outranks && !blocked)  kind = SRC_MASK;
        else                            kind = SRC_NONE;
    end

endmodule

// File: rtl/intr_prio_ctrl.sv
// Module: intr_prio_ctrl (top)
// Central interrupt control byte with its acceptance decision, the
// save stack used in nested mode and the sticky overflow flag.
// Assumes ack_i and ret_i are single-cycle strobes from the controller.
// A software write takes precedence over any acknowledge or return in
// the same cycle.
module intr_prio_ctrl
    import intr_prio_pkg::*;
#(
    parameter int STACK_DEPTH = 7,
    localparam int DW = $clog2(STACK_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid_i,
    input  logic [PRIO_W-1:0] req_prio_i,
    input  logic              top_req_i,
    input  logic              nmi_req_i,
    input  logic              ack_i,
    input  logic              ret_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wr_data_i,
    input  logic              timer_ce_i,
    output logic [7:0]        rd_data_o,
    output logic [1:0]        accept_kind_o,
    output logic              ovf_o,
    output logic [DW-1:0]     save_depth_o,
    output logic              counter_en_o
);

    ctl_reg_t          ctl_q, ctl_d;
    logic              ovf_q, ovf_d;
    src_e              kind;
    logic              blocked;
    logic              push, pop;
    logic [PRIO_W-1:0] saved_lvl;
    logic              st_full, st_empty;

    prio_arbiter u_arb (
        .req_valid (req_valid_i),
        .req_prio  (req_prio_i),
        .nmi_req   (nmi_req_i),
        .tlip      (ctl_q.tlip),
        .tli       (ctl_q.tli),
        .gie       (ctl_q.gie),
        .nest      (ctl_q.nest),
        .cpl       (ctl_q.cpl),
        .stack_full(st_full),
        .kind      (kind),
        .blocked   (blocked)
    );

    prio_save_lifo #(.DEPTH(STACK_DEPTH), .W(PRIO_W)) u_lifo (
        .clk  (clk),
        .rst_n(rst_n),
        .push (push),
        .pop  (pop),
        .din  (ctl_q.cpl),
        .dout (saved_lvl),
        .full (st_full),
        .empty(st_empty),
        .count(save_depth_o)
    );

    // Next control byte: a write first, then acknowledge, then return; the top request is ORed in last.
    always_comb begin
        ctl_d = ctl_q;
        push  = 1'b0;
        pop   = 1'b0;
        if (wr_en_i) begin
            ctl_d = ctl_reg_t'(wr_data_i);
        end else if (ack_i && (kind != SRC_NONE)) begin
            case (kind)
                SRC_MASK: begin
                    ctl_d.cpl = req_prio_i;
                    if (ctl_q.nest) push      = 1'b1;
                    else            ctl_d.gie = 1'b0;
                end
                SRC_TOP:  ctl_d.tlip = 1'b0;
                default:  ;
            endcase
        end else if (ret_i) begin
            if (ctl_q.nest) begin
                if (!st_empty) begin
                    pop       = 1'b1;
                    ctl_d.cpl = saved_lvl;
                end
            end else begin
                ctl_d.gie = 1'b1;
            end
        end
        if (top_req_i) ctl_d.tlip = 1'b1;
        ovf_d = wr_en_i ? 1'b0 : (ovf_q | blocked);
    end

    // Control byte and overflow flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RESET;
            ovf_q <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
            ovf_q <= ovf_d;
        end
    end

    // Output views of the state.
    always_comb begin
        rd_data_o     = ctl_q;
        accept_kind_o = kind;
        ovf_o         = ovf_q;
        counter_en_o  = ctl_q.gce & timer_ce_i;
    end

    p_rank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SRC_MASK) |-> (ctl_q.gie && (req_prio_i < ctl_q.cpl)));

    p_nmi_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && nmi_req_i && !wr_en_i && !top_req_i) |=> (rd_data_o == $past(rd_data_o)));

    p_conc_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && kind == SRC_MASK && !ctl_q.nest && !wr_en_i) |=> !ctl_q.gie);

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && !wr_en_i) |=> ovf_q);

    p_tlip_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        top_req_i |=> ctl_q.tlip);

endmodule

// File: tb/tb_intr_prio_ctrl.sv
module tb_intr_prio_ctrl;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req_valid_i, top_req_i, nmi_req_i, ack_i, ret_i, wr_en_i, timer_ce_i;
    logic [2:0] req_prio_i;
    logic [7:0] wr_data_i;
    logic [7:0] rd_data_o;
    logic [1:0] accept_kind_o;
    logic       ovf_o, counter_en_o;
    logic [2:0] save_depth_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 0;

    // Reference model state
    int m_gce, m_tlip, m_tli, m_gie, m_nest, m_cpl, m_ovf;
    int q[$];
    int seen_kind;

    always #10 clk = ~clk;

    intr_prio_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid_i), .req_prio_i(req_prio_i),
        .top_req_i(top_req_i), .nmi_req_i(nmi_req_i),
        .ack_i(ack_i), .ret_i(ret_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .timer_ce_i(timer_ce_i),
        .rd_data_o(rd_data_o), .accept_kind_o(accept_kind_o),
        .ovf_o(ovf_o), .save_depth_o(save_depth_o),
        .counter_en_o(counter_en_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int m_byte();
        return (m_gce << 7) | (m_tlip << 6) | (m_tli << 5) | (m_gie << 4) | (m_nest << 3) | m_cpl;
    endfunction

    task automatic m_reset();
        m_gce = 1; m_tlip = 0; m_tli = 0; m_gie = 0; m_nest = 0; m_cpl = 7; m_ovf = 0;
        q.delete();
    endtask

    // Drive one cycle, compare against the model, then advance both.
    task automatic step(input bit rv, input int pr, input bit tq, input bit nm,
                        input bit ak, input bit rt, input bit we, input int wd, input bit tce);
        int k, outr, blk;
        req_valid_i = rv; req_prio_i = pr[2:0]; top_req_i = tq; nmi_req_i = nm;
        ack_i = ak; ret_i = rt; wr_en_i = we; wr_data_i = wd[7:0]; timer_ce_i = tce;
        #2;
        outr = (rv && m_gie && pr < m_cpl) ? 1 : 0;
        blk  = (outr && m_nest && q.size() == 7) ? 1 : 0;
        if (nm) k = 3;
        else if (m_tlip && m_tli && m_gie) k = 2;
        else if (outr && !blk) k = 1;
        else k = 0;
        seen_kind = accept_kind_o;
        chk("R2 R3 R7 accept kind", accept_kind_o, k);
        chk("R9 control byte", rd_data_o, m_byte());
        chk("R6 overflow flag", ovf_o, m_ovf);
        chk("R5 save depth", save_depth_o, q.size());
        chk("R8 counter enable", counter_en_o, m_gce & tce);
        @(posedge clk);
        if (we) begin
            m_gce = wd[7]; m_tlip = wd[6]; m_tli = wd[5]; m_gie = wd[4];
            m_nest = wd[3]; m_cpl = wd & 7; m_ovf = 0;
        end else begin
            if (blk) m_ovf = 1;
            if (ak && k != 0) begin
                if (k == 1) begin
                    if (m_nest) q.push_back(m_cpl); else m_gie = 0;
                    m_cpl = pr;
                end else if (k == 2) m_tlip = 0;
            end else if (rt) begin
                if (m_nest) begin
                    if (q.size() != 0) m_cpl = q.pop_back();
                end else m_gie = 1;
            end
        end
        if (tq) m_tlip = 1;
        @(negedge clk);
    endtask

    task automatic idle(); step(0, 0, 0, 0, 0, 0, 0, 0, 0); endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        req_valid_i = 0; req_prio_i = 0; top_req_i = 0; nmi_req_i = 0;
        ack_i = 0; ret_i = 0; wr_en_i = 0; wr_data_i = 0; timer_ce_i = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_reset();
        // R1 reset state
        chk("R1 reset byte", rd_data_o, 8'h87);
        chk("R1 reset depth", save_depth_o, 0);
        chk("R1 reset overflow", ovf_o, 0);
        chk("R1 reset kind", accept_kind_o, 0);

        // R2 global enable clear blocks ordinary requests
        step(1, 2, 0, 0, 1, 0, 0, 0, 0);
        chk("R2 gie clear refuses", seen_kind, 0);
        // R3 NMI always wins, ack leaves byte alone
        step(1, 2, 0, 1, 1, 0, 0, 0, 1);
        chk("R3 nmi accepted", seen_kind, 3);
        chk("R3 byte after nmi ack", rd_data_o, 8'h87);

        // Concurrent mode, gie set, level 7
        step(0, 0, 0, 0, 0, 0, 1, 8'h97, 0);
        step(1, 7, 0, 0, 0, 0, 0, 0, 0);
        chk("R2 equal level refused", seen_kind, 0);
        step(1, 6, 0, 0, 1, 0, 0, 0, 0);
        chk("R2 higher rank accepted", seen_kind, 1);
        chk("R4 ack clears gie loads level", rd_data_o, 8'h86);
        step(1, 0, 0, 0, 1, 0, 0, 0, 0);
        chk("R4 masked while gie clear", seen_kind, 0);
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R4 return sets gie", rd_data_o, 8'h96);

        // R5 nested fill to the limit
        step(0, 0, 0, 0, 0, 0, 1, 8'h9F, 0);
        for (int p = 6; p >= 0; p--) step(1, p, 0, 0, 1, 0, 0, 0, 0);
        chk("R5 level after fill", rd_data_o, 8'h98);
        chk("R6 depth at limit", save_depth_o, 7);
        // Raise level by software; stack stays full
        step(0, 0, 0, 0, 0, 0, 1, 8'h9F, 0);
        chk("R9 write keeps stack", save_depth_o, 7);
        step(1, 3, 0, 0, 1, 0, 0, 0, 0);
        chk("R6 full stack refuses", seen_kind, 0);
        chk("R6 overflow raised", ovf_o, 1);
        chk("R10 ack with nothing accepted", rd_data_o, 8'h9F);
        idle();
        chk("R6 overflow sticky", ovf_o, 1);
        for (int p = 1; p <= 7; p++) begin
            step(0, 0, 0, 0, 0, 1, 0, 0, 0);
            chk("R5 pop restores level", rd_data_o & 7, p);
        end
        step(0, 0, 0, 0, 0, 1, 0, 0, 0);
        chk("R10 empty return keeps level", rd_data_o, 8'h9F);
        step(0, 0, 0, 0, 0, 0, 1, 8'h97, 0);
        chk("R6 write clears overflow", ovf_o, 0);

        // R7 top-level path
        step(0, 0, 1, 0, 0, 0, 0, 0, 0);
        chk("R7 request sets pending", rd_data_o[6], 1);
        idle();
        chk("R7 pending without enable", seen_kind, 0);
        step(0, 0, 0, 0, 0, 0, 1, 8'hF7, 0);
        step(1, 1, 0, 1, 0, 0, 0, 0, 0);
        chk("R7 nmi over top", seen_kind, 3);
        step(1, 1, 0, 0, 1, 0, 0, 0, 0);
        chk("R7 top over ordinary", seen_kind, 2);
        chk("R7 ack clears pending", rd_data_o, 8'hB7);
        step(0, 0, 0, 0, 0, 0, 1, 8'hF7, 0);
        chk("R7 software sets pending", rd_data_o[6], 1);
        // R9 write beats ack; same-cycle top request still lands
        step(1, 2, 1, 0, 1, 0, 1, 8'h17, 0);
        chk("R9 write wins with top request", rd_data_o, 8'h57);
        // R8 counter gating
        step(0, 0, 0, 0, 0, 0, 1, 8'h80, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8 gate high", counter_en_o, 1);
        step(0, 0, 0, 0, 0, 0, 1, 8'h00, 1);
        #2 chk("R8 gate low", counter_en_o, 0);

        // Random stretch
        for (int i = 0; i < 4000; i++) begin
            bit we;
            int wd;
            we = ($urandom % 40) == 0;
            wd = $urandom % 256;
            if (($urandom % 3) != 0) wd = wd | 8'h18;
            step($urandom % 2, $urandom % 8, ($urandom % 8) == 0, ($urandom % 16) == 0,
                 $urandom % 2, ($urandom % 4) == 0, we, wd, $urandom % 2);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule